// File: doc/BRIEF.md
# Host Byte Handshake Engine

This block is the controller side of a byte-wide packet link with a host. The host owns two active-low handshake lines, transfer-in-progress and acknowledge, and a shared shift byte. The engine samples both lines every clock. Each time the pair changes during a transfer, it moves one byte. When the host is sending, the engine stores the shift byte in a small receive array. When the host is receiving, the engine presents the next byte of a pending reply on its shift output. The engine drives an active-low transfer-request line back to the host: it pulls the line low when a reply is waiting and releases it when the last reply byte has been taken.

While the link is idle, the request line follows the acknowledge line each time the host toggles it, which gives the host a sync handshake. Every moved byte and every sync toggle raises a one-cycle shift-complete interrupt pulse. The pulse comes after a programmable number of clock cycles. It comes in the very next cycle when that count is zero or when the port direction value has all eight bits set to output. When the host ends a send sequence, the engine reports a packet-ready pulse together with the byte count.

Reply bytes are loaded through a push port while the link is idle. Received bytes are read back through an address port.

Top module: `hshk_link_engine`

## Requirements
- R1: After reset, `req_n` is 1 and `sh_load`, `shift_irq` and `pkt_ready` are 0.
- R2: With `host_tip_n` low and `aux_send` = 1, every cycle in which {`host_tip_n`,`host_ack_n`} differs from its value in the previous cycle stores `sh_in` at the next receive slot. This includes the cycle in which `host_tip_n` first falls. Stored bytes read back in arrival order at `rx_rd_addr` 0, 1, ... on `rx_rd_data`, and each store schedules a shift interrupt.
- R3: Once RX_DEPTH bytes are held, further pair changes store nothing, overwrite nothing and schedule no interrupt.
- R4: When `host_tip_n` rises and at least one byte was received, `pkt_ready` pulses for exactly one cycle with `pkt_len` equal to the count, and the receive count returns to zero. A rise with no bytes received gives no pulse.
- R5: With `host_tip_n` low, `aux_send` = 0 and reply bytes pending, every pair change puts the next reply byte, in push order, on `sh_out` with a one-cycle `sh_load` pulse, and schedules a shift interrupt.
- R6: Taking the last reply byte sets `req_n` to 1 in the next cycle and empties the reply array. Further pair changes load nothing.
- R7: While `host_tip_n` is high and reply bytes are pending, `req_n` is driven to 0.
- R8: With `host_tip_n` high in this cycle and the previous one, a change of `host_ack_n` sets `req_n` to the new `host_ack_n` value and schedules a shift interrupt.
- R9: For `dly_cycles` = d ≥ 1 and `pb_dir` ≠ 8'hFF, `shift_irq` pulses once, for one cycle, d cycles after the cycle in which the event was registered.
- R10: When `dly_cycles` = 0 or `pb_dir` = 8'hFF, `shift_irq` pulses in the cycle right after the event, with no later pulse.
- R11: An event that arrives while a delay is still counting restarts the count from `dly_cycles`, and only one pulse results.
- R12: `rep_push` is ignored while `host_tip_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| host_tip_n | input | 1 | Transfer-in-progress from host, active low |
| host_ack_n | input | 1 | Transfer acknowledge from host, active low |
| aux_send | input | 1 | Transfer direction: 1 = host sends, 0 = host receives |
| pb_dir | input | 8 | Port direction value; 8'hFF bypasses the interrupt delay |
| sh_in | input | 8 | Shift byte written by the host |
| dly_cycles | input | DLY_W | Interrupt delay in clock cycles |
| rep_push | input | 1 | Append `rep_byte` to the reply array |
| rep_byte | input | 8 | Reply byte to append |
| rx_rd_addr | input | log2(RX_DEPTH) | Receive array read address |
| rx_rd_data | output | 8 | Receive array byte at `rx_rd_addr` |
| req_n | output | 1 | Transfer request to host, active low |
| sh_out | output | 8 | Reply byte presented to the host |
| sh_load | output | 1 | One-cycle pulse when `sh_out` takes a new byte |
| shift_irq | output | 1 | Shift-complete interrupt pulse |
| pkt_ready | output | 1 | One-cycle pulse at the end of a send sequence |
| pkt_len | output | log2(RX_DEPTH+1) | Received byte count, valid with `pkt_ready` |

## Verification
The assertions assume that the handshake lines are already synchronous to `clk` and that `aux_send` does not change while a transfer is in progress. They also assume that `dly_cycles` is held steady while a delay is counting. The bench changes the handshake lines, the direction and the delay only at falling clock edges. It changes direction and delay only while the link is idle and no interrupt is outstanding. Every send and reply sequence starts from an idle link with a settled request line.

// File: rtl/hshk_pkg.sv
package hshk_pkg;
  typedef enum logic [1:0] {
    REQ_HOLD,
    REQ_RELEASE,
    REQ_ASSERT,
    REQ_FOLLOW_ACK
  } req_act_e;
endpackage

// File: rtl/hshk_edge_track.sv
module hshk_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tip_n,
  input  logic ack_n,
  output logic pair_chg,
  output logic tip_rose,
  output logic idle_ack_chg
);
  logic last_tip_q, last_ack_q;

  always_comb begin
    pair_chg     = (tip_n != last_tip_q) || (ack_n != last_ack_q);
    tip_rose     = tip_n && !last_tip_q;
    idle_ack_chg = tip_n && last_tip_q && (ack_n != last_ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tip_q <= 1'b1;
      last_ack_q <= 1'b1;
    end else begin
      last_tip_q <= tip_n;
      last_ack_q <= ack_n;
    end
  end
endmodule

// File: rtl/hshk_rx_store.sv
module hshk_rx_store #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [7:0]                 cap_byte,
  input  logic                       clr,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    wr_en   = cap_en && !full;
    cnt_d   = cnt_q;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = cnt_q + 1'b1;
    cnt     = cnt_q;
    rd_data = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt_q[AW-1:0]] <= cap_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_rx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/hshk_reply_store.sv
module hshk_reply_store #(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_ok,
  input  logic [7:0] push_byte,
  input  logic       take,
  output logic       pending,
  output logic       last,
  output logic [7:0] head
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          push_en;

  always_comb begin
    pending = (rd_q != wr_q);
    last    = pending && ((rd_q + 1'b1) == wr_q);
    head    = mem[rd_q[AW-1:0]];
    push_en = push && push_ok && (wr_q != CW'(DEPTH));
    wr_d    = wr_q;
    rd_d    = rd_q;
    if (take && last) begin
      wr_d = '0;
      rd_d = '0;
    end else if (take && pending) begin
      rd_d = rd_q + 1'b1;
    end else if (push_en) begin
      wr_d = wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en && !take) mem[wr_q[AW-1:0]] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assert_ptr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q < wr_q) || (wr_q == '0 && rd_q == '0));
  assert_empty_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> !pending);
endmodule

// File: rtl/hshk_irq_delay.sv
module hshk_irq_delay #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched,
  input  logic          bypass,
  input  logic [DW-1:0] dly,
  output logic          irq
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (sched) begin
      if (bypass) begin
        irq_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = dly;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      irq_d = (cnt_q == DW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  assert_bypass_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && bypass) |=> irq);
  assert_quiet_while_counting_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sched && cnt_q > DW'(1)) |=> !irq);
  assert_restart_no_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && !bypass) |=> !irq);
endmodule

// File: rtl/hshk_link_engine.sv
module hshk_link_engine #(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned DLY_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_tip_n,
  input  logic                          host_ack_n,
  input  logic                          aux_send,
  input  logic [7:0]                    pb_dir,
  input  logic [7:0]                    sh_in,
  input  logic [DLY_W-1:0]              dly_cycles,
  input  logic                          rep_push,
  input  logic [7:0]                    rep_byte,
  input  logic [$clog2(RX_DEPTH)-1:0]   rx_rd_addr,
  output logic [7:0]                    rx_rd_data,
  output logic                          req_n,
  output logic [7:0]                    sh_out,
  output logic                          sh_load,
  output logic                          shift_irq,
  output logic                          pkt_ready,
  output logic [$clog2(RX_DEPTH+1)-1:0] pkt_len
);
  import hshk_pkg::*;

  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1);

  logic pair_chg, tip_rose, idle_ack_chg;
  logic cap_en, rep_take, sched, bypass;
  logic rx_full, rep_pend, rep_last;
  logic [RX_CW-1:0] rx_cnt;
  logic [7:0] rep_head;
  req_act_e req_act;

  logic             req_q, req_d;
  logic [7:0]       sh_out_q, sh_out_d;
  logic             sh_load_q;
  logic             pkt_rdy_q, pkt_rdy_d;
  logic [RX_CW-1:0] pkt_len_q, pkt_len_d;

  hshk_edge_track u_edge (
    .clk(clk), .rst_n(rst_n), .tip_n(host_tip_n), .ack_n(host_ack_n),
    .pair_chg(pair_chg), .tip_rose(tip_rose), .idle_ack_chg(idle_ack_chg)
  );

  hshk_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_byte(sh_in),
    .clr(tip_rose), .rd_addr(rx_rd_addr), .rd_data(rx_rd_data),
    .cnt(rx_cnt), .full(rx_full)
  );

  hshk_reply_store #(.DEPTH(TX_DEPTH)) u_rep (
    .clk(clk), .rst_n(rst_n), .push(rep_push), .push_ok(host_tip_n),
    .push_byte(rep_byte), .take(rep_take), .pending(rep_pend),
    .last(rep_last), .head(rep_head)
  );

  hshk_irq_delay #(.DW(DLY_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sched(sched), .bypass(bypass),
    .dly(dly_cycles), .irq(shift_irq)
  );

  always_comb begin
    cap_en   = !host_tip_n && aux_send && pair_chg && !rx_full;
    rep_take = !host_tip_n && !aux_send && pair_chg && rep_pend;
    sched    = cap_en || rep_take || idle_ack_chg;
    bypass   = (dly_cycles == '0) || (pb_dir == 8'hFF);

    if (rep_take && rep_last)       req_act = REQ_RELEASE;
    else if (idle_ack_chg)          req_act = REQ_FOLLOW_ACK;
    else if (host_tip_n && rep_pend) req_act = REQ_ASSERT;
    else                            req_act = REQ_HOLD;

    case (req_act)
      REQ_RELEASE:    req_d = 1'b1;
      REQ_ASSERT:     req_d = 1'b0;
      REQ_FOLLOW_ACK: req_d = host_ack_n;
      default:        req_d = req_q;
    endcase

    sh_out_d  = rep_take ? rep_head : sh_out_q;
    pkt_rdy_d = tip_rose && (rx_cnt != '0);
    pkt_len_d = pkt_rdy_d ? rx_cnt : pkt_len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b1;
      sh_out_q  <= '0;
      sh_load_q <= 1'b0;
      pkt_rdy_q <= 1'b0;
      pkt_len_q <= '0;
    end else begin
      req_q     <= req_d;
      sh_out_q  <= sh_out_d;
      sh_load_q <= rep_take;
      pkt_rdy_q <= pkt_rdy_d;
      pkt_len_q <= pkt_len_d;
    end
  end

  assign req_n     = req_q;
  assign sh_out    = sh_out_q;
  assign sh_load   = sh_load_q;
  assign pkt_ready = pkt_rdy_q;
  assign pkt_len   = pkt_len_q;

  assert_release_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_take && rep_last) |=> req_n);
  assert_pkt_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> $past(tip_rose));
  assert_load_only_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> $past(!host_tip_n && !aux_send));
  assert_sync_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack_chg |=> (req_n == $past(host_ack_n)));
  assert_pending_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tip_n && rep_pend && !idle_ack_chg) |=> !req_n);
endmodule

// File: tb/sim_hshk_link_engine.sv
module sim_hshk_link_engine;
  localparam int CLK_P = 10;
  localparam int RXD   = 4;
  localparam int TXD   = 4;
  localparam int DW    = 6;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, tip_n, ack_n, aux_send, rep_push, sh_load, shift_irq, pkt_ready, req_n;
  logic [7:0] pb_dir, sh_in, rep_byte, rx_rd_data, sh_out;
  logic [DW-1:0] dly;
  logic [1:0] rx_rd_addr;
  logic [2:0] pkt_len;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  hshk_link_engine #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_tip_n(tip_n), .host_ack_n(ack_n),
    .aux_send(aux_send), .pb_dir(pb_dir), .sh_in(sh_in), .dly_cycles(dly),
    .rep_push(rep_push), .rep_byte(rep_byte), .rx_rd_addr(rx_rd_addr),
    .rx_rd_data(rx_rd_data), .req_n(req_n), .sh_out(sh_out), .sh_load(sh_load),
    .shift_irq(shift_irq), .pkt_ready(pkt_ready), .pkt_len(pkt_len)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fs(input int n, input int k);
    return 8'(n * 37 + k * 11 + 5);
  endfunction

  function automatic logic [7:0] fr(input int n, input int k);
    return 8'(n * 53 + k * 29 + 140);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog all requirements actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tip_n = 1'b1; ack_n = 1'b1; aux_send = 1'b1; pb_dir = 8'hFF;
    sh_in = 8'h00; dly = DW'(5); rep_push = 1'b0; rep_byte = 8'h00; rx_rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_n == 1'b1, "R1 req_n after reset", req_n, 1);
    chk(sh_load == 1'b0, "R1 sh_load after reset", sh_load, 0);
    chk(shift_irq == 1'b0, "R1 shift_irq after reset", shift_irq, 0);
    chk(pkt_ready == 1'b0, "R1 pkt_ready after reset", pkt_ready, 0);

    // R2 R3 R4: send sequences of every length up to past full
    for (int n = 1; n <= RXD + 2; n++) begin
      int kept;
      kept = (n < RXD) ? n : RXD;
      for (int k = 0; k < n; k++) begin
        sh_in = fs(n, k);
        if (k == 0) tip_n = 1'b0; else ack_n = ~ack_n;
        @(negedge clk);
        if (k < RXD) chk(shift_irq == 1'b1, "R2 capture irq", shift_irq, 1);
        else         chk(shift_irq == 1'b0, "R3 full no irq", shift_irq, 0);
      end
      tip_n = 1'b1;
      @(negedge clk);
      chk(pkt_ready == 1'b1, "R4 pkt_ready", pkt_ready, 1);
      chk(int'(pkt_len) == kept, "R4 pkt_len", pkt_len, kept);
      for (int a = 0; a < kept; a++) begin
        rx_rd_addr = 2'(a);
        #1;
        chk(rx_rd_data == fs(n, a), "R2 stored byte", rx_rd_data, fs(n, a));
      end
      @(negedge clk);
      chk(pkt_ready == 1'b0, "R4 single pulse", pkt_ready, 0);
    end

    // R4: receive transfer with nothing received gives no packet
    aux_send = 1'b0;
    tip_n = 1'b0;
    @(negedge clk);
    ack_n = ~ack_n;
    @(negedge clk);
    chk(sh_load == 1'b0, "R5 nothing pending no load", sh_load, 0);
    tip_n = 1'b1;
    @(negedge clk);
    chk(pkt_ready == 1'b0, "R4 no pulse when empty", pkt_ready, 0);

    // R5 R6 R7: replies of every length
    for (int n = 1; n <= TXD; n++) begin
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        rep_push = 1'b1; rep_byte = fr(n, k);
        @(negedge clk);
      end
      rep_push = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(req_n == 1'b0, "R7 request with pending reply", req_n, 0);
      for (int k = 0; k < n; k++) begin
        if (k == 0) tip_n = 1'b0; else ack_n = ~ack_n;
        @(negedge clk);
        chk(sh_load == 1'b1, "R5 load pulse", sh_load, 1);
        chk(sh_out == fr(n, k), "R5 reply byte order", sh_out, fr(n, k));
        chk(shift_irq == 1'b1, "R5 reply irq", shift_irq, 1);
        chk(req_n == (k == n - 1), "R6 req_n on last", req_n, (k == n - 1));
      end
      ack_n = ~ack_n;
      @(negedge clk);
      chk(sh_load == 1'b0, "R6 nothing after last", sh_load, 0);
      tip_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(req_n == 1'b1, "R6 idle released", req_n, 1);
    end

    // R12: push during transfer is ignored
    for (int k = 0; k < 2; k++) begin
      rep_push = 1'b1; rep_byte = fr(9, k);
      @(negedge clk);
    end
    rep_push = 1'b0;
    @(negedge clk);
    tip_n = 1'b0;
    @(negedge clk);
    chk(sh_out == fr(9, 0), "R12 first byte", sh_out, fr(9, 0));
    rep_push = 1'b1; rep_byte = 8'hEE;
    @(negedge clk);
    rep_push = 1'b0;
    chk(sh_load == 1'b0, "R12 push alone no load", sh_load, 0);
    ack_n = ~ack_n;
    @(negedge clk);
    chk(sh_out == fr(9, 1), "R12 second byte", sh_out, fr(9, 1));
    chk(req_n == 1'b1, "R12 last byte releases", req_n, 1);
    ack_n = ~ack_n;
    @(negedge clk);
    chk(sh_load == 1'b0, "R12 pushed byte absent", sh_load, 0);
    tip_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_n == 1'b1, "R12 no pending after", req_n, 1);

    // R8: idle sync follows ack
    for (int i = 0; i < 6; i++) begin
      ack_n = ~ack_n;
      @(negedge clk);
      chk(req_n == ack_n, "R8 req follows ack", req_n, ack_n);
      chk(shift_irq == 1'b1, "R8 sync irq", shift_irq, 1);
    end

    // R9: delay sweep
    pb_dir = 8'h00;
    for (int d = 1; d <= 20; d++) begin
      int cnt, first;
      cnt = 0; first = 0;
      dly = DW'(d);
      ack_n = ~ack_n;
      for (int k = 1; k <= d + 3; k++) begin
        @(negedge clk);
        if (shift_irq) begin
          cnt++;
          if (first == 0) first = k;
        end
      end
      chk(cnt == 1, "R9 single pulse", cnt, 1);
      chk(first == d + 1, "R9 delay cycles", first, d + 1);
    end

    // R10: bypass by zero delay and by all-output direction
    dly = '0;
    ack_n = ~ack_n;
    @(negedge clk);
    chk(shift_irq == 1'b1, "R10 zero delay", shift_irq, 1);
    pb_dir = 8'hFF; dly = DW'(20);
    ack_n = ~ack_n;
    @(negedge clk);
    chk(shift_irq == 1'b1, "R10 dir all out", shift_irq, 1);
    begin
      int late;
      late = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (shift_irq) late++;
      end
      chk(late == 0, "R10 no later pulse", late, 0);
    end

    // R11: restart while counting
    pb_dir = 8'h00; dly = DW'(10);
    ack_n = ~ack_n;
    begin
      int early, cnt, first;
      early = 0; cnt = 0; first = 0;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        if (shift_irq) early++;
      end
      ack_n = ~ack_n;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        if (shift_irq) begin
          cnt++;
          if (first == 0) first = k;
        end
      end
      chk(early == 0, "R11 none before restart", early, 0);
      chk(cnt == 1, "R11 single pulse", cnt, 1);
      chk(first == 11, "R11 restarted delay", first, 11);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule